// File: doc/BRIEF.md
# Link Retry Transmitter

This block sits on the transmit side of a serial link, between the transaction layer and the wire. Each packet it accepts gets a 12-bit sequence number and a 32-bit link CRC. A copy goes into a replay buffer, and the framed packet is sent. New packets are accepted only while the far end has flow-control credit and the replay buffer has a free slot.

The far end answers with acknowledge and negative-acknowledge messages, each carrying a sequence number. An acknowledge frees every buffered packet up to and including that number. A negative acknowledge frees the same packets and then resends the rest in their original order. Sequence numbers are compared modulo 4096. If no acknowledge arrives for too long, a timer starts the same replay as a negative acknowledge.

The link side has no back-pressure: a frame presented with `link_valid` is taken in that cycle. Credits are returned one at a time on `fc_return`. Only first transmissions consume a credit; replays do not.

Top module: `link_retry_tx`

## Requirements
- R1: Accepted packets get consecutive sequence numbers starting at 0 after reset and wrapping from 4095 to 0. The number is sent on `link_seq` with the packet.
- R2: `link_crc` is computed over the 48-bit frame {4'b0000, link_seq, link_data}, most significant bit first. It uses polynomial 0x04C11DB7 with the register seeded to all ones, and the result is inverted.
- R3: A packet accepted at a clock edge (`tl_valid` and `tl_ready` high) appears on the link at the following edge, with `link_data` equal to the accepted `tl_data`. Packets appear in acceptance order, each exactly once unless replayed.
- R4: `tl_ready` is low while DEPTH packets are unacknowledged (default 8), and the count of unacknowledged packets never exceeds DEPTH.
- R5: A new packet needs at least one credit and consumes one. Each `fc_return` pulse adds one credit. The counter starts at INIT_CREDITS (default 12), and replays consume no credit.
- R6: An acknowledge (`dl_valid` high, `dl_nak` low) for sequence N inside the window frees all packets up to and including N. The window runs from the last acknowledged number up to the newest sent number, modulo 4096.
- R7: A negative acknowledge (`dl_nak` high) for N inside the window frees packets up to N and then resends N+1 through the newest, in order. If N equals the last acknowledged number, every unacknowledged packet is resent.
- R8: An acknowledge or negative acknowledge whose number lies outside the window is ignored. It frees nothing, starts no replay and does not restart the timer.
- R9: While packets are unacknowledged and no replay is running, TIMEOUT cycles (default 64) without an accepted acknowledge start a replay of all unacknowledged packets. With nothing unacknowledged, nothing is resent.
- R10: After reset, `link_valid` is low and `tl_ready` is high.
- R11: `tl_ready` is low while a replay is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tl_valid | input | 1 | Packet offered by the transaction layer |
| tl_ready | output | 1 | Packet is taken at this edge if tl_valid is high |
| tl_data | input | DATA_W | Packet payload |
| fc_return | input | 1 | One flow-control credit returned |
| dl_valid | input | 1 | Acknowledge message present |
| dl_nak | input | 1 | 1 = negative acknowledge, 0 = acknowledge |
| dl_seq | input | SEQ_W | Sequence number carried by the message |
| link_valid | output | 1 | Frame on the link this cycle |
| link_seq | output | SEQ_W | Sequence number of the frame |
| link_data | output | DATA_W | Payload of the frame |
| link_crc | output | 32 | Link CRC of the frame |

## Verification
The assertions assume that credit returns never push the credit count past its width, and that no negative acknowledge or timeout lands while a replay is still being read out. They also assume that `tl_valid` is low whenever reset is high. The stimulus meets these conditions. It returns credits only after packets have used them. It waits for each replay to drain before sending the next acknowledge message, and it holds every input low during reset. Out-of-window numbers are still driven on purpose, so the window check itself is exercised.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic {SRC_NEW = 1'b0, SRC_REPLAY = 1'b1} lrt_src_e;
endpackage

// File: rtl/lrt_crc.sv
module lrt_crc #(
  parameter int IN_W = 48
) (
  input  logic [IN_W-1:0] frame,
  output logic [31:0]     crc
);
  import lrt_pkg::*;

  logic [31:0] acc;
  logic        fb;

  always_comb begin
    acc = CRC_SEED;
    fb  = 1'b0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      fb  = acc[31] ^ frame[i];
      acc = {acc[30:0], 1'b0};
      if (fb) acc = acc ^ CRC_POLY;
    end
    crc = ~acc;
  end
endmodule

// File: rtl/lrt_replay_ram.sv
module lrt_replay_ram #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/lrt_credit_gate.sv
module lrt_credit_gate #(
  parameter int CRED_W       = 8,
  parameter int INIT_CREDITS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic ret,
  input  logic take,
  output logic credit_ok
);
  logic [CRED_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= CRED_W'(INIT_CREDITS);
    else     cnt <= cnt + CRED_W'(ret) - CRED_W'(take);
  end

  assign credit_ok = (cnt != '0);
endmodule

// File: rtl/lrt_replay_timer.sv
module lrt_replay_timer #(
  parameter int TIMEOUT = 64,
  localparam int TW     = $clog2(TIMEOUT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic expired
);
  logic [TW-1:0] cnt;
  logic          at_end;

  assign at_end  = (cnt == TW'(TIMEOUT - 1));
  assign expired = run && !clear && at_end;

  always_ff @(posedge clk) begin
    if (rst || clear || !run) cnt <= '0;
    else if (at_end)          cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/link_retry_tx.sv
module link_retry_tx #(
  parameter int DATA_W       = 32,
  parameter int SEQ_W        = 12,
  parameter int DEPTH        = 8,
  parameter int CRED_W       = 8,
  parameter int INIT_CREDITS = 12,
  parameter int TIMEOUT      = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tl_valid,
  output logic              tl_ready,
  input  logic [DATA_W-1:0] tl_data,
  input  logic              fc_return,
  input  logic              dl_valid,
  input  logic              dl_nak,
  input  logic [SEQ_W-1:0]  dl_seq,
  output logic              link_valid,
  output logic [SEQ_W-1:0]  link_seq,
  output logic [DATA_W-1:0] link_data,
  output logic [31:0]       link_crc
);
  import lrt_pkg::*;

  localparam int AW      = $clog2(DEPTH);
  localparam int FRAME_W = ((SEQ_W + DATA_W + 7) / 8) * 8;

  // sequence bookkeeping
  logic [SEQ_W-1:0] next_seq, acked, outstanding;
  logic             full, credit_ok, accept;
  // acknowledge decode
  logic [SEQ_W-1:0] d_off, new_acked, start_seq;
  logic             dl_in_win, ack_ok, nak_ok, tmo_fire;
  // replay state
  logic             replaying, rpl_nxt, rd_issue;
  logic [SEQ_W-1:0] rp, rp_nxt, rp_end, rpend_nxt, rd_seq, cur, rp_off;
  // stage 1
  logic             s1_valid;
  lrt_src_e         s1_src;
  logic [SEQ_W-1:0] s1_seq;
  logic [DATA_W-1:0] s1_data, rd_data, frame_data;
  logic [FRAME_W-1:0] frame;
  logic [31:0]      crc_val;

  assign outstanding = next_seq - acked - 1'b1;
  assign full        = (outstanding == SEQ_W'(DEPTH));
  assign tl_ready    = !replaying && !full && credit_ok;
  assign accept      = tl_valid && tl_ready;

  assign d_off     = dl_seq - acked;
  assign dl_in_win = dl_valid && (d_off <= outstanding);
  assign ack_ok    = dl_in_win && !dl_nak;
  assign nak_ok    = dl_in_win && dl_nak;
  assign new_acked = dl_in_win ? dl_seq : acked;
  assign start_seq = new_acked + 1'b1;
  assign rp_off    = rp - acked;

  lrt_credit_gate #(.CRED_W(CRED_W), .INIT_CREDITS(INIT_CREDITS)) u_credit (
    .clk(clk), .rst(rst), .ret(fc_return), .take(accept), .credit_ok(credit_ok)
  );

  lrt_replay_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst(rst),
    .run((outstanding != '0) && !replaying),
    .clear(dl_in_win),
    .expired(tmo_fire)
  );

  always_comb begin
    rd_issue  = 1'b0;
    rd_seq    = rp;
    rp_nxt    = rp;
    rpl_nxt   = replaying;
    rpend_nxt = rp_end;
    cur       = rp;
    if (nak_ok || tmo_fire) begin
      if (start_seq != next_seq) begin
        rpl_nxt   = 1'b1;
        rp_nxt    = start_seq;
        rpend_nxt = next_seq;
      end else begin
        rpl_nxt = 1'b0;
      end
    end else if (replaying) begin
      if (ack_ok && (d_off >= rp_off)) cur = dl_seq + 1'b1;
      if (cur == rp_end) begin
        rpl_nxt = 1'b0;
        rp_nxt  = cur;
      end else begin
        rd_issue = 1'b1;
        rd_seq   = cur;
        rp_nxt   = cur + 1'b1;
        rpl_nxt  = ((cur + 1'b1) != rp_end);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_seq  <= '0;
      acked     <= '1;
      replaying <= 1'b0;
      rp        <= '0;
      rp_end    <= '0;
    end else begin
      if (accept) next_seq <= next_seq + 1'b1;
      acked     <= new_acked;
      replaying <= rpl_nxt;
      rp        <= rp_nxt;
      rp_end    <= rpend_nxt;
    end
  end

  lrt_replay_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk),
    .we(accept), .waddr(next_seq[AW-1:0]), .wdata(tl_data),
    .re(rd_issue), .raddr(rd_seq[AW-1:0]), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_src   <= SRC_NEW;
      s1_seq   <= '0;
      s1_data  <= '0;
    end else begin
      s1_valid <= accept || rd_issue;
      s1_src   <= rd_issue ? SRC_REPLAY : SRC_NEW;
      s1_seq   <= rd_issue ? rd_seq : next_seq;
      s1_data  <= tl_data;
    end
  end

  assign frame_data = (s1_src == SRC_NEW) ? s1_data : rd_data;
  assign frame      = FRAME_W'({s1_seq, frame_data});

  lrt_crc #(.IN_W(FRAME_W)) u_crc (.frame(frame), .crc(crc_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      link_valid <= 1'b0;
      link_seq   <= '0;
      link_data  <= '0;
      link_crc   <= '0;
    end else begin
      link_valid <= s1_valid;
      link_seq   <= s1_seq;
      link_data  <= frame_data;
      link_crc   <= crc_val;
    end
  end
endmodule

// File: rtl/lrt_checker.sv
module lrt_checker #(
  parameter int SEQ_W = 12,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tl_valid,
  input logic             tl_ready,
  input logic             link_valid,
  input logic [SEQ_W-1:0] link_seq,
  input logic [SEQ_W-1:0] next_seq,
  input logic [SEQ_W-1:0] outstanding,
  input logic             replaying,
  input logic             credit_ok
);
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    outstanding <= SEQ_W'(DEPTH));

  a_r4_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (outstanding == SEQ_W'(DEPTH)) |-> !tl_ready);

  a_r5_no_credit_blocks: assert property (@(posedge clk) disable iff (rst)
    !credit_ok |-> !tl_ready);

  a_r11_replay_blocks: assert property (@(posedge clk) disable iff (rst)
    replaying |-> !tl_ready);

  a_r1_seq_step: assert property (@(posedge clk) disable iff (rst)
    (tl_valid && tl_ready) |=> (next_seq == $past(next_seq) + 1'b1));

  a_r3_latency: assert property (@(posedge clk) disable iff (rst)
    (tl_valid && tl_ready) |=> ##1 (link_valid && link_seq == $past(next_seq, 2)));
endmodule

bind link_retry_tx lrt_checker #(.SEQ_W(SEQ_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .tl_valid(tl_valid), .tl_ready(tl_ready),
  .link_valid(link_valid), .link_seq(link_seq), .next_seq(next_seq),
  .outstanding(outstanding), .replaying(replaying), .credit_ok(credit_ok)
);

// File: tb/tb_link_retry_tx.sv
module tb_link_retry_tx;
  localparam int TMO = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tl_valid = 1'b0;
  logic        tl_ready;
  logic [31:0] tl_data = '0;
  logic        fc_return = 1'b0;
  logic        dl_valid = 1'b0;
  logic        dl_nak = 1'b0;
  logic [11:0] dl_seq = '0;
  logic        link_valid;
  logic [11:0] link_seq;
  logic [31:0] link_data;
  logic [31:0] link_crc;

  always #2 clk = ~clk;

  link_retry_tx #(.DATA_W(32), .SEQ_W(12), .DEPTH(8), .CRED_W(8),
                  .INIT_CREDITS(12), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst(rst), .tl_valid(tl_valid), .tl_ready(tl_ready),
    .tl_data(tl_data), .fc_return(fc_return), .dl_valid(dl_valid),
    .dl_nak(dl_nak), .dl_seq(dl_seq), .link_valid(link_valid),
    .link_seq(link_seq), .link_data(link_data), .link_crc(link_crc)
  );

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  int nbeats = 0;
  int b_next = 0;
  int b_acked = 4095;
  logic [31:0] bdat [4096];
  int exp_seq [$];
  logic [31:0] exp_dat [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [11:0] s, input logic [31:0] d);
    logic [47:0] m;
    logic [31:0] r;
    m = {4'h0, s, d};
    r = 32'hFFFF_FFFF;
    for (int i = 47; i >= 0; i--)
      r = {r[30:0], 1'b0} ^ ((r[31] ^ m[i]) ? 32'h04C1_1DB7 : 32'h0);
    return ~r;
  endfunction

  // link monitor: every beat is compared against the expected queue
  always @(negedge clk) begin
    if (!rst && link_valid) begin
      nbeats++;
      if (exp_seq.size() == 0) begin
        chk(1'b0, "R3", "unexpected beat seq", link_seq, 0);
      end else begin
        chk(link_seq == 12'(exp_seq[0]), "R1", "link_seq", link_seq, exp_seq[0]);
        chk(link_data == exp_dat[0], "R3", "link_data", link_data, exp_dat[0]);
        chk(link_crc == ref_crc(link_seq, link_data), "R2", "link_crc",
            link_crc, ref_crc(link_seq, link_data));
        void'(exp_seq.pop_front());
        void'(exp_dat.pop_front());
      end
    end
  end

  task automatic send(input logic [31:0] d);
    @(negedge clk);
    while (!tl_ready) @(negedge clk);
    tl_valid = 1'b1;
    tl_data  = d;
    @(posedge clk);
    #1 tl_valid = 1'b0;
    bdat[b_next] = d;
    exp_seq.push_back(b_next);
    exp_dat.push_back(d);
    b_next = (b_next + 1) % 4096;
  endtask

  task automatic credit_ret();
    @(negedge clk);
    fc_return = 1'b1;
    @(posedge clk);
    #1 fc_return = 1'b0;
  endtask

  task automatic push_replay_from(input int first);
    for (int s = first; s != b_next; s = (s + 1) % 4096) begin
      exp_seq.push_back(s);
      exp_dat.push_back(bdat[s]);
    end
  endtask

  task automatic dll(input bit nak, input int s);
    int d;
    int outs;
    @(negedge clk);
    dl_valid = 1'b1;
    dl_nak   = nak;
    dl_seq   = 12'(s);
    @(posedge clk);
    #1 dl_valid = 1'b0;
    d    = (s - b_acked) & 4095;
    outs = (b_next - b_acked - 1) & 4095;
    if (d <= outs) begin
      b_acked = s;
      if (nak) push_replay_from((s + 1) % 4096);
    end
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (exp_seq.size() == 0) break;
    end
    repeat (3) @(negedge clk);
    chk(exp_seq.size() == 0, req, "pending beats", exp_seq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int cnt;
    int t0;
    int el;
    int nb0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(tl_ready == 1'b1, "R10", "tl_ready after reset", tl_ready, 1);
    chk(link_valid == 1'b0, "R10", "link_valid after reset", link_valid, 0);

    // R3 latency: visible after the edge following acceptance
    send(32'hA000_0000);
    @(negedge clk);
    chk(link_valid == 1'b0, "R3", "valid too early", link_valid, 0);
    @(negedge clk);
    chk(link_valid == 1'b1, "R3", "valid one edge after", link_valid, 1);
    for (int i = 1; i < 5; i++) send(32'hA000_0000 + 32'(i));
    drain("R1");

    // R6 ack purges, then R4 fill to DEPTH
    dll(1'b0, 2);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!tl_ready) break;
      send(32'hB000_0000 + 32'(k));
      cnt++;
    end
    chk(cnt == 6, "R6", "packets accepted after ack 2", cnt, 6);
    @(negedge clk);
    chk(tl_ready == 1'b0, "R4", "tl_ready when full", tl_ready, 0);
    drain("R4");

    // R7 nak replays 7..10
    dll(1'b1, 6);
    drain("R7");

    // R8 out-of-window ack ignored; later nak 8 must still replay 9,10
    dll(1'b0, 3000);
    repeat (5) @(negedge clk);
    chk(exp_seq.size() == 0, "R8", "beats after bogus ack", exp_seq.size(), 0);
    dll(1'b1, 8);
    chk(exp_seq.size() == 2, "R8", "replay size after nak 8", exp_seq.size(), 2);
    drain("R8");

    // R9 timeout replay of 9,10
    push_replay_from((b_acked + 1) % 4096);
    t0 = cyc;
    for (int k = 0; k < 4 * TMO; k++) begin
      @(negedge clk);
      if (exp_seq.size() == 0) break;
    end
    el = cyc - t0;
    chk(exp_seq.size() == 0, "R9", "timeout replay missing", exp_seq.size(), 0);
    chk(el >= TMO - 8 && el <= TMO + 8, "R9", "timeout delay", el, TMO);
    repeat (3) @(negedge clk);
    dll(1'b0, 10);
    nb0 = nbeats;
    repeat (3 * TMO) @(negedge clk);
    chk(nbeats == nb0, "R9", "beats with nothing outstanding", nbeats, nb0);

    // R5 credits: 11 sent, replays took none, one credit left
    send(32'hC000_000B);
    @(negedge clk);
    chk(tl_ready == 1'b0, "R5", "tl_ready with zero credit", tl_ready, 0);
    credit_ret();
    @(negedge clk);
    chk(tl_ready == 1'b1, "R5", "tl_ready after credit return", tl_ready, 1);
    dll(1'b0, 11);
    drain("R5");

    // R7 duplicate nak replays everything outstanding
    for (int k = 0; k < 10; k++) credit_ret();
    for (int k = 0; k < 3; k++) send(32'hD000_0000 + 32'(k));
    dll(1'b1, 11);
    chk(exp_seq.size() >= 3, "R7", "dup nak queued replay", exp_seq.size(), 6);
    drain("R7");
    dll(1'b0, 14);

    // R1 wrap sweep
    while (b_next != 4094) begin
      send(32'(b_next) * 32'h0001_0003);
      credit_ret();
      dll(1'b0, (b_next + 4095) % 4096);
    end
    drain("R1");
    for (int k = 0; k < 3; k++) send(32'hE000_0000 + 32'(k));
    chk(b_next == 1, "R1", "bench seq wrapped", b_next, 1);
    dll(1'b1, 4094);
    drain("R7");
    dll(1'b0, 0);
    @(negedge clk);
    chk(tl_ready == 1'b1, "R1", "tl_ready after wrap ack", tl_ready, 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule